// File: doc/BRIEF.md
# Atomic Set/Clear/Masked-Write Control Register Bank

This block holds a small bank of 32-bit control words for a pin controller. It sits on a simple memory-mapped bus that carries at most one access per cycle. Each control word owns a group of four consecutive word addresses. One address holds the word itself. The other three are write-only aliases:

- a bit-set alias,
- a bit-clear alias,
- a per-field masked-write alias.

Because of these aliases, several bus masters can each change their own bits or fields of a shared word without a read-modify-write sequence that could race with another master.

Each word is divided into equal mode fields of `FIELD_W` bits. In a masked write, the top bit of each field is that field's modify-enable. The bits below it are the new mode for that field.

Changing a multi-bit field to a value that is neither all zeros nor all ones takes a set write followed by a clear write. The masked-write alias does it in one access. The held words are presented on a flat output vector that drives the pin multiplexing logic.

Top module: `bankctl_atomic_regs`

## Requirements
- R1: The bus address is a word address. Bits [1:0] select the access kind: 0 = value, 1 = set, 2 = clear, 3 = masked write. The bits above them select the register. A write changes only the addressed register.
- R2: A write at access kind 0 replaces every implemented bit of the register with the written data.
- R3: A write at kind 1 forces to 1 every register bit whose written bit is 1. All other bits keep their value.
- R4: A write at kind 2 forces to 0 every register bit whose written bit is 1. All other bits keep their value.
- R5: In a write at kind 3, consider each field f, which occupies bits [f*FIELD_W+FIELD_W-1 : f*FIELD_W]. If its top bit is 1, the field is loaded with {0, written lower FIELD_W-1 bits}. If its top bit is 0, the field is unchanged. For example, with 4-bit fields, written values 8 to 15 load modes 0 to 7.
- R6: FIELD_W of 3, 4 and 5 are supported, giving 10, 8 and 6 fields per word.
- R7: A read at kind 0 returns the addressed register's contents in the same cycle. A read at kind 1, 2 or 3 returns zero, and so does the data output when no read is in progress.
- R8: A set or clear write with all-zero data leaves the register unchanged.
- R9: While the synchronous active-high reset is high, every register loads RESET_VAL with its unimplemented bits forced to zero.
- R10: The bits above the last whole field are unimplemented. They stay zero and read as zero whatever is written, through any alias.
- R11: A write takes effect at the clock edge on which it is presented. Both the output vector and a read in the following cycle show the new contents, and neither changes before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address: {register index, access kind} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| ctrl_out | output | NUM_REGS*32 | All held registers; register i is at bits [i*32+31:i*32] |

## Verification
The bench builds three copies of the bank with four registers each: field widths 4, 3 and 5, and reset values A5A55A5A, all ones and zero. The 4-bit copy walks a vector table of set, clear, masked and plain writes on one register while a neighbour is watched for disturbance. The 3-bit and 5-bit copies leave two spare top bits. With them the bench can show that those bits are dropped from reset, plain and set writes, and how a masked write behaves when the field boundaries do not line up with hex digits. An all-ones reset value makes the spare-bit masking visible straight out of reset.

// File: rtl/bankctl_pkg.sv
package bankctl_pkg;

    localparam int WORD_W = 32;
    localparam int KIND_W = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [KIND_W-1:0] {
        ALIAS_VALUE = 2'd0,
        ALIAS_SET   = 2'd1,
        ALIAS_CLEAR = 2'd2,
        ALIAS_FIELD = 2'd3
    } alias_e;

    typedef struct packed {
        logic   hit;
        alias_e kind;
    } reg_cmd_t;

    // Bits covered by whole fields of width fw
    function automatic word_t used_mask(int fw);
        word_t m;
        int    n;
        n = (WORD_W / fw) * fw;
        m = '0;
        for (int i = 0; i < WORD_W; i++)
            if (i < n) m[i] = 1'b1;
        return m;
    endfunction

    // Modify-enable (top) bit position of every whole field
    function automatic word_t enable_mask(int fw);
        word_t m;
        m = '0;
        for (int f = 0; f < WORD_W / fw; f++)
            m[f*fw + fw - 1] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/bankctl_decode.sv
module bankctl_decode
    import bankctl_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 4
) (
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [ADDR_W-1:0]       bus_addr,
    output reg_cmd_t [NUM_REGS-1:0] cmd
);
    localparam int IDX_W = ADDR_W - KIND_W;

    logic [IDX_W-1:0] idx;
    alias_e           kind;

    assign idx  = bus_addr[ADDR_W-1:KIND_W];
    assign kind = alias_e'(bus_addr[KIND_W-1:0]);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign cmd[i].hit  = bus_valid && bus_write && (idx == IDX_W'(i));
        assign cmd[i].kind = kind;
    end
endmodule

// File: rtl/bankctl_slice.sv
module bankctl_slice
    import bankctl_pkg::*;
#(
    parameter int    FIELD_W   = 4,
    parameter word_t RESET_VAL = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  reg_cmd_t cmd,
    input  word_t    wdata,
    output word_t    q
);
    localparam int    FIELDS  = WORD_W / FIELD_W;
    localparam word_t USED    = used_mask(FIELD_W);
    localparam word_t EN_BITS = enable_mask(FIELD_W);

    word_t merged;
    word_t nxt;

    // Masked field write: each field's top bit gates its own update
    always_comb begin
        merged = '0;
        for (int f = 0; f < FIELDS; f++) begin
            if (wdata[f*FIELD_W + FIELD_W - 1])
                merged[f*FIELD_W +: FIELD_W] = {1'b0, wdata[f*FIELD_W +: FIELD_W-1]};
            else
                merged[f*FIELD_W +: FIELD_W] = q[f*FIELD_W +: FIELD_W];
        end
    end

    always_comb begin
        unique case (cmd.kind)
            ALIAS_VALUE: nxt = wdata;
            ALIAS_SET:   nxt = q | wdata;
            ALIAS_CLEAR: nxt = q & ~wdata;
            ALIAS_FIELD: nxt = merged;
            default:     nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= RESET_VAL & USED;
        else if (cmd.hit)
            q <= nxt & USED;
    end

    a_r9_reset_value: assert property (@(posedge clk)
        rst |=> (q == (RESET_VAL & USED)));

    a_r3_set_bits: assert property (@(posedge clk) disable iff (rst)
        (cmd.hit && cmd.kind == ALIAS_SET) |=>
        ((q & $past(wdata & USED)) == $past(wdata & USED)));

    a_r4_clear_bits: assert property (@(posedge clk) disable iff (rst)
        (cmd.hit && cmd.kind == ALIAS_CLEAR) |=> ((q & $past(wdata)) == '0));

    a_r1_unaddressed_hold: assert property (@(posedge clk) disable iff (rst)
        !cmd.hit |=> $stable(q));

    a_r5_disabled_fields_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd.hit && cmd.kind == ALIAS_FIELD && (wdata & EN_BITS) == '0) |=> $stable(q));

    a_r8_zero_set_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd.hit && (cmd.kind == ALIAS_SET || cmd.kind == ALIAS_CLEAR) && wdata == '0)
        |=> $stable(q));

    a_r10_spare_zero: assert property (@(posedge clk) disable iff (rst)
        (q & ~USED) == '0);
endmodule

// File: rtl/bankctl_readmux.sv
module bankctl_readmux
    import bankctl_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 4
) (
    input  logic                       bus_valid,
    input  logic                       bus_write,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [NUM_REGS*WORD_W-1:0] regs,
    output word_t                      rdata
);
    localparam int IDX_W = ADDR_W - KIND_W;

    logic [IDX_W-1:0] idx;
    alias_e           kind;

    assign idx  = bus_addr[ADDR_W-1:KIND_W];
    assign kind = alias_e'(bus_addr[KIND_W-1:0]);

    always_comb begin
        rdata = '0;
        if (bus_valid && !bus_write && kind == ALIAS_VALUE && int'(idx) < NUM_REGS)
            rdata = regs[idx*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/bankctl_atomic_regs.sv
module bankctl_atomic_regs
    import bankctl_pkg::*;
#(
    parameter int    NUM_REGS  = 4,
    parameter int    FIELD_W   = 4,
    parameter word_t RESET_VAL = '0,
    localparam int   ADDR_W    = $clog2(NUM_REGS) + KIND_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_valid,
    input  logic                       bus_write,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [WORD_W-1:0]          bus_wdata,
    output logic [WORD_W-1:0]          bus_rdata,
    output logic [NUM_REGS*WORD_W-1:0] ctrl_out
);
    reg_cmd_t [NUM_REGS-1:0] cmd;

    bankctl_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .cmd       (cmd)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        bankctl_slice #(.FIELD_W(FIELD_W), .RESET_VAL(RESET_VAL)) u_slice (
            .clk   (clk),
            .rst   (rst),
            .cmd   (cmd[i]),
            .wdata (bus_wdata),
            .q     (ctrl_out[i*WORD_W +: WORD_W])
        );
    end

    bankctl_readmux #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_readmux (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .regs      (ctrl_out),
        .rdata     (bus_rdata)
    );

    a_r7_value_read_matches: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_addr[KIND_W-1:0] == 2'd0) |->
        (bus_rdata == ctrl_out[bus_addr[ADDR_W-1:KIND_W]*WORD_W +: WORD_W]));

    a_r7_alias_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_addr[KIND_W-1:0] != 2'd0) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_bankctl_atomic_regs.sv
module sim_bankctl_atomic_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  vld = 3'b000;
    logic        wr  = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wd  = '0;
    logic [31:0] rd0, rd1, rd2;
    logic [127:0] co0, co1, co2;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bankctl_atomic_regs #(.NUM_REGS(4), .FIELD_W(4), .RESET_VAL(32'hA5A5_5A5A)) u0 (
        .clk(clk), .rst(rst), .bus_valid(vld[0]), .bus_write(wr), .bus_addr(addr),
        .bus_wdata(wd), .bus_rdata(rd0), .ctrl_out(co0));
    bankctl_atomic_regs #(.NUM_REGS(4), .FIELD_W(3), .RESET_VAL(32'hFFFF_FFFF)) u1 (
        .clk(clk), .rst(rst), .bus_valid(vld[1]), .bus_write(wr), .bus_addr(addr),
        .bus_wdata(wd), .bus_rdata(rd1), .ctrl_out(co1));
    bankctl_atomic_regs #(.NUM_REGS(4), .FIELD_W(5), .RESET_VAL(32'h0)) u2 (
        .clk(clk), .rst(rst), .bus_valid(vld[2]), .bus_write(wr), .bus_addr(addr),
        .bus_wdata(wd), .bus_rdata(rd2), .ctrl_out(co2));

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] data;
        logic [31:0] expv;
    } vec_t;

    // Register 2 of u0 (4-bit fields), starting from A5A55A5A
    localparam vec_t VEC [12] = '{
        '{2'd1, 32'h0000_00F0, 32'hA5A5_5AFA},   // R3 set
        '{2'd2, 32'h0F00_0000, 32'hA0A5_5AFA},   // R4 clear
        '{2'd1, 32'h0000_0000, 32'hA0A5_5AFA},   // R8 zero set
        '{2'd2, 32'h0000_0000, 32'hA0A5_5AFA},   // R8 zero clear
        '{2'd3, 32'h0000_0009, 32'hA0A5_5AF1},   // R5 one field
        '{2'd3, 32'hF000_000F, 32'h70A5_5AF7},   // R5 two fields
        '{2'd3, 32'h0080_0000, 32'h7005_5AF7},   // R5 load mode 0
        '{2'd3, 32'h7777_7777, 32'h7005_5AF7},   // R5 no enables
        '{2'd0, 32'h1357_9BDF, 32'h1357_9BDF},   // R2 plain
        '{2'd3, 32'h8888_8888, 32'h0000_0000},   // R5 all to 0
        '{2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},   // R3 all set
        '{2'd3, 32'hCCCC_CCCC, 32'h4444_4444}    // R5 all to 4
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, expv);
        end
    endtask

    task automatic bus_wr(input int inst, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        vld = 3'b000; vld[inst] = 1'b1; wr = 1'b1; addr = a; wd = d;
        @(negedge clk);
        vld = 3'b000; wr = 1'b0; wd = '0;
    endtask

    task automatic bus_rd(input int inst, input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        vld = 3'b000; vld[inst] = 1'b1; wr = 1'b0; addr = a;
        #1;
        case (inst)
            0:       d = rd0;
            1:       d = rd1;
            default: d = rd2;
        endcase
        vld = 3'b000;
    endtask

    logic [31:0] r;
    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state
        for (int i = 0; i < 4; i++) begin
            bus_rd(0, {i[1:0], 2'd0}, r);
            check("R9 u0 reset value", r, 32'hA5A5_5A5A);
        end
        bus_rd(1, 4'd0, r);  check("R9 R10 u1 reset spare bits", r, 32'h3FFF_FFFF);
        bus_rd(2, 4'd12, r); check("R9 u2 reset", r, 32'h0);
        bus_rd(0, {2'd2, 2'd1}, r); check("R7 set alias reads zero", r, 32'h0);
        bus_rd(0, {2'd2, 2'd3}, r); check("R7 masked alias reads zero", r, 32'h0);
        check("R7 idle rdata zero", rd0, 32'h0);

        // Table walk on u0 register 2
        for (int k = 0; k < 12; k++) begin
            bus_wr(0, {2'd2, VEC[k].kind}, VEC[k].data);
            check("R2 R3 R4 R5 R8 R11 table output", co0[95:64], VEC[k].expv);
            bus_rd(0, {2'd2, 2'd0}, r);
            check("R7 R11 table readback", r, VEC[k].expv);
            check("R1 neighbour untouched", co0[63:32], 32'hA5A5_5A5A);
        end

        // Only the addressed register changes
        bus_wr(0, {2'd3, 2'd0}, 32'hDEAD_BEEF);
        check("R1 reg3 written", co0[127:96], 32'hDEAD_BEEF);
        check("R1 reg0 untouched", co0[31:0], 32'hA5A5_5A5A);
        check("R1 reg2 untouched", co0[95:64], 32'h4444_4444);

        // 3-bit fields, 2 spare bits
        bus_wr(1, {2'd0, 2'd3}, 32'h0000_0004);
        check("R6 R5 w3 mode 0", co1[31:0], 32'h3FFF_FFF8);
        bus_wr(1, {2'd0, 2'd3}, 32'hFFFF_FFFF);
        check("R6 R5 R10 w3 all mode 3", co1[31:0], 32'h1B6D_B6DB);
        bus_wr(1, {2'd0, 2'd1}, 32'hC000_0000);
        check("R10 set spare ignored", co1[31:0], 32'h1B6D_B6DB);
        bus_wr(1, {2'd0, 2'd0}, 32'hFFFF_FFFF);
        bus_rd(1, 4'd0, r);
        check("R2 R10 w3 plain write", r, 32'h3FFF_FFFF);
        check("R1 w3 reg1 untouched", co1[63:32], 32'h3FFF_FFFF);

        // 5-bit fields
        bus_wr(2, {2'd1, 2'd3}, 32'h0000_0013);
        check("R6 R5 w5 field0", co2[63:32], 32'h0000_0003);
        bus_wr(2, {2'd1, 2'd3}, 32'h3E00_0000);
        check("R6 R5 w5 top field", co2[63:32], 32'h1E00_0003);
        bus_wr(2, {2'd1, 2'd2}, 32'h0000_0003);
        check("R4 w5 clear", co2[63:32], 32'h1E00_0000);

        // Timing: no change before the edge, change after
        @(negedge clk);
        vld = 3'b100; wr = 1'b1; addr = {2'd0, 2'd1}; wd = 32'h0000_00FF;
        #1;
        check("R11 before edge", co2[31:0], 32'h0);
        @(negedge clk);
        vld = 3'b000; wr = 1'b0; wd = '0;
        check("R11 after edge", co2[31:0], 32'h0000_00FF);
        bus_wr(2, {2'd0, 2'd1}, 32'hFFFF_FFFF);
        check("R10 w5 set spare ignored", co2[31:0], 32'h3FFF_FFFF);

        // Mid-run reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R9 reset reload u0", co0[95:64], 32'hA5A5_5A5A);
        check("R9 reset reload u1", co1[31:0], 32'h3FFF_FFFF);
        check("R9 reset reload u2", co2[31:0], 32'h0);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule